// File: doc/BRIEF.md
# S/PDIF Transmit Channel Status Store

This block supplies the channel status bit for every subframe of an S/PDIF transmitter. A host loads two 24-byte staging images, one per channel, over a byte-wide write port. At each block boundary the staging images are copied into an active transmit copy. The active copy is then played out one bit per subframe, and the block repeats for as long as the host leaves it alone.

The host has three control inputs. A buffer-select input chooses whether a write lands in the channel A or the channel B image. A mirror input makes both channels carry the channel A image. A hold input stops the boundary copy, so the host can finish rewriting both images and the transmitter keeps sending the previous contents until then.

The transmitter gives one strobe per subframe, a channel flag, and a block-start flag on the first subframe of each block. Biphase coding, preambles and user bits belong to neighbouring logic.

Top module: `cs_tx_store`

## Requirements
- R1: Each channel image holds 24 bytes. Bit j of byte k is block bit 8k+j, so byte 0 bit 0 is sent first and each byte goes out LSB first.
- R2: A write with `img_sel`=0 updates the channel A image, and a write with `img_sel`=1 updates the channel B image.
- R3: `cs_bit` changes only on a clock edge where `sub_stb` is high. After that edge it carries the current bit of channel A when `sub_chan`=0, or of channel B when `sub_chan`=1.
- R4: The bit index advances after each channel B subframe and wraps from 191 to 0 without `blk_start`, so the block repeats.
- R5: When `mirror_a` is high at a block boundary, both channels send the channel A image for that block.
- R6: When `copy_hold` is high at a block boundary, the previous active contents are sent again. The first boundary after it is lowered sends the current images.
- R7: The active copy changes only at a block boundary. Writes made during a block do not alter the rest of that block.
- R8: After reset, all images and the active copy are zero, so `cs_bit` is 0 and every block sent is all zeros.
- R9: A write to an address of 24 or above changes nothing.
- R10: A subframe strobed with `blk_start` high carries bit 0 whatever the running count is. It must be a channel A subframe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host byte write strobe |
| wr_addr | input | 5 | Byte address within the image |
| wr_data | input | 8 | Byte to write |
| img_sel | input | 1 | 0 writes the A image, 1 writes the B image |
| mirror_a | input | 1 | Send the A image on both channels |
| copy_hold | input | 1 | Block the boundary copy |
| sub_stb | input | 1 | One pulse per subframe |
| sub_chan | input | 1 | Channel of the strobed subframe (0 = A, 1 = B) |
| blk_start | input | 1 | First subframe of a block |
| cs_bit | output | 1 | Channel status bit for the strobed subframe |

## Verification
The hardest case to reach is a host write that lands in the middle of a block while the active copy is already committed. The bench stops a block partway, rewrites byte 0 and a byte late in the image, and then resumes. It checks that the remaining bits of that block stay old and that the following block carries the new bytes. The hold case works the same way: new data is loaded while the hold is up, the repeated block is shown to be unchanged, and the first block after the hold is released must carry the new data.

// File: rtl/cs_tx_store.sv
module cs_tx_store #(
  parameter int BYTES = 24
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [$clog2(BYTES)-1:0]   wr_addr,
  input  logic [7:0]                 wr_data,
  input  logic                       img_sel,
  input  logic                       mirror_a,
  input  logic                       copy_hold,
  input  logic                       sub_stb,
  input  logic                       sub_chan,
  input  logic                       blk_start,
  output logic                       cs_bit
);
  localparam int BITS = BYTES * 8;
  localparam int IW   = $clog2(BITS);
  localparam int AW   = $clog2(BYTES);

  logic [BITS-1:0] stg_a, stg_b, act_a, act_b;
  logic [IW-1:0]   fcnt;

  wire [IW-1:0]    idx_now = blk_start ? '0 : fcnt;
  wire [IW-1:0]    idx_inc = (idx_now == IW'(BITS - 1)) ? '0 : idx_now + 1'b1;
  wire             load    = sub_stb & blk_start & ~copy_hold;
  wire [BITS-1:0]  nxt_b   = mirror_a ? stg_a : stg_b;
  wire [BITS-1:0]  src_a   = load ? stg_a : act_a;
  wire [BITS-1:0]  src_b   = load ? nxt_b : act_b;
  wire             addr_ok = {1'b0, wr_addr} < (AW + 1)'(BYTES);
  wire [AW+2:0]    base    = {wr_addr, 3'b000};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg_a <= '0;
      stg_b <= '0;
    end else if (wr_en && addr_ok) begin
      if (img_sel) stg_b[base +: 8] <= wr_data;
      else         stg_a[base +: 8] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_a <= '0;
      act_b <= '0;
    end else if (load) begin
      act_a <= stg_a;
      act_b <= nxt_b;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fcnt   <= '0;
      cs_bit <= 1'b0;
    end else if (sub_stb) begin
      fcnt   <= sub_chan ? idx_inc : idx_now;
      cs_bit <= sub_chan ? src_b[idx_now] : src_a[idx_now];
    end
  end

  a_r4_index_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    fcnt < IW'(BITS));

  a_r4_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_stb && sub_chan && !blk_start && fcnt == IW'(BITS - 1)) |=> (fcnt == '0));

  a_r3_bit_held: assert property (@(posedge clk) disable iff (!rst_n)
    !sub_stb |=> $stable(cs_bit));

  a_r6_hold_keeps_active: assert property (@(posedge clk) disable iff (!rst_n)
    (copy_hold && sub_stb && blk_start) |=> ($stable(act_a) && $stable(act_b)));

  a_r7_mid_block_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !(sub_stb && blk_start) |=> ($stable(act_a) && $stable(act_b)));

  a_r9_bad_addr_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr_ok) |=> ($stable(stg_a) && $stable(stg_b)));

  a_r10_start_on_a: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_stb && blk_start) |-> !sub_chan);
endmodule

// File: tb/cs_tx_store_test.sv
module cs_tx_store_test;
  localparam int BYTES = 24;
  localparam int BITS  = BYTES * 8;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, img_sel = 0, mirror_a = 0, copy_hold = 0;
  logic [4:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic sub_stb = 0, sub_chan = 0, blk_start = 0;
  logic cs_bit;

  int checks = 0, errors = 0;
  logic [BITS-1:0] m_stg_a = '0, m_stg_b = '0, m_act_a = '0, m_act_b = '0;
  logic [BITS-1:0] got_a, got_b;

  always #10 clk = ~clk;

  cs_tx_store #(.BYTES(BYTES)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .img_sel(img_sel), .mirror_a(mirror_a), .copy_hold(copy_hold),
    .sub_stb(sub_stb), .sub_chan(sub_chan), .blk_start(blk_start), .cs_bit(cs_bit));

  task automatic check(input string req, input logic [BITS-1:0] act, input logic [BITS-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic write_byte(input logic sel, input int addr, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; img_sel = sel; wr_addr = 5'(addr); wr_data = d;
    @(negedge clk);
    wr_en = 0;
    if (addr < BYTES) begin
      if (sel) m_stg_b[addr*8 +: 8] = d;
      else     m_stg_a[addr*8 +: 8] = d;
    end
  endtask

  task automatic subframe(input logic ch, input logic st, output logic b);
    @(negedge clk);
    sub_stb = 1; sub_chan = ch; blk_start = st;
    @(negedge clk);
    sub_stb = 0; blk_start = 0;
    b = cs_bit;
  endtask

  task automatic frames(input int first, input int last, input logic use_start);
    for (int f = first; f <= last; f++) begin
      logic ba, bb;
      if (f == 0 && use_start && !copy_hold) begin
        m_act_a = m_stg_a;
        m_act_b = mirror_a ? m_stg_a : m_stg_b;
      end
      subframe(1'b0, use_start && f == 0, ba);
      subframe(1'b1, 1'b0, bb);
      got_a[f] = ba;
      got_b[f] = bb;
    end
  endtask

  task automatic block_check(input string req, input logic use_start);
    frames(0, BITS - 1, use_start);
    check({req, " chA"}, got_a, m_act_a);
    check({req, " chB"}, got_b, m_act_b);
  endtask

  task automatic t_reset;
    check("R8 reset cs_bit", {{(BITS-1){1'b0}}, cs_bit}, '0);
    block_check("R8 zero block", 1);
  endtask

  task automatic t_load_both;
    for (int k = 0; k < BYTES; k++) begin
      write_byte(0, k, 8'(8'hA1 + k * 7));
      write_byte(1, k, 8'(8'h3C ^ (k * 13)));
    end
    block_check("R1 R2 order and select", 1);
    block_check("R4 repeat without start", 0);
  endtask

  task automatic t_hold_strobe;
    logic b0, b1;
    subframe(0, 1, b0);
    repeat (5) @(negedge clk);
    b1 = cs_bit;
    checks++;
    if (b1 !== b0) begin
      errors++;
      $display("FAIL R3 hold between strobes: actual %b expected %b", b1, b0);
    end
    subframe(1, 0, b1);
    frames(1, BITS - 1, 0);
  endtask

  task automatic t_mirror;
    mirror_a = 1;
    block_check("R5 mirror", 1);
    mirror_a = 0;
    block_check("R5 mirror off", 1);
  endtask

  task automatic t_copy_hold;
    copy_hold = 1;
    write_byte(0, 3, 8'h5A);
    write_byte(1, 20, 8'hC3);
    block_check("R6 hold repeats old", 1);
    copy_hold = 0;
    block_check("R6 release copies", 1);
  endtask

  task automatic t_mid_block;
    logic [BITS-1:0] exp_a;
    exp_a = m_stg_a;
    frames(0, 9, 1);
    write_byte(0, 0, 8'hFF);
    write_byte(0, 22, 8'h81);
    frames(10, BITS - 1, 0);
    check("R7 block unchanged by mid write", got_a, exp_a);
    block_check("R7 next block new", 1);
  endtask

  task automatic t_bad_addr;
    write_byte(0, 24, 8'hEE);
    write_byte(1, 31, 8'h77);
    block_check("R9 out-of-range ignored", 1);
  endtask

  task automatic t_resync;
    frames(0, 49, 0);
    block_check("R10 start forces bit 0", 1);
  endtask

  initial begin
    #(20ns * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_load_both();
    t_hold_strobe();
    t_mirror();
    t_copy_hold();
    t_mid_block();
    t_bad_addr();
    t_resync();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule